// File: doc/BRIEF.md
# Converter Control and Result Register Block

This block is the register-facing side of a 12-bit analog-to-digital converter on an 8-bit peripheral bus. One control/status byte holds a start bit, a read-only busy flag, an enable bit, a result alignment select and a three-bit input selector. Two further bytes expose the upper and lower parts of the last converted value.

Software starts a conversion in two writes. The first sets the start bit and the second clears it. On the clearing write the block raises busy and sends a one-cycle request, with the selected input code, to an external converter core. The core answers with a one-cycle done pulse and a 12-bit value. The block then stores that value into the high/low result pair, using the alignment selected at that moment, and drops busy. While the converter is switched off, the result pair does not change. Switching the converter off during a conversion abandons that conversion.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset the control byte (address 0), the high result byte (address 1) and the low result byte (address 2) all read 0x00. Address 3 always reads 0x00.
- R2: Control bit 3 always reads 0. A write to control bit 6 (busy) has no effect on the value read back.
- R3: A request is issued only by a control write with bit 7 = 0 while the stored start bit is 1, following an earlier write with bit 7 = 1. Writing bit 7 = 1 alone, or writing 0 while the stored start bit is 0, issues no request.
- R4: `conv_req` is high for exactly one cycle. That cycle directly follows the clocked clearing write. `conv_chan` then carries the value of control bits 2..0 unchanged (000 input 0, 010 input 2, 110 input 6, 111 input 7; other codes are undefined and are passed through as written).
- R5: Busy (control bit 6) reads 1 from the cycle after the accepted clearing write until the cycle after the core's done pulse. A done pulse while busy is 0 changes nothing.
- R6: A start sequence completed while busy is 1 issues no request and does not disturb the running conversion.
- R7: A start sequence whose clearing write has enable (bit 5) = 0 sets no busy and issues no request.
- R8: With alignment bit 4 = 0 at completion, the high byte reads result[11:4] and the low byte reads {0000, result[3:0]}.
- R9: With alignment bit 4 = 1 at completion, the high byte reads {0000, result[11:8]} and the low byte reads result[7:0].
- R10: Clearing enable during a conversion drops busy at once. The abandoned conversion never updates the result bytes, which stay unchanged while enable is 0.
- R11: `conv_en` follows the stored enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 2 | Register address (0 control, 1 high, 2 low) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| conv_en | output | 1 | Converter power enable |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Input selector sent with the request |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_data | input | 12 | Converted value, valid with `conv_done` |

## Verification
The bench covers several ways to start a conversion wrongly. It writes start alone, repeats the set step, writes a clear with no set before it, and completes the sequence while disabled. A design that started on a plain write of one, or on any write of zero, would show a request count that is too high. It restarts while busy and injects stray done pulses while idle, which would expose a second request or a result overwritten outside a conversion. It also turns the converter off in the middle of a conversion: a design that kept busy set or stored the late value would read back wrongly. Random inputs, alignments and values check both alignment layouts against a bench function.

// File: rtl/adc_ctrl_regs_pkg.sv
package adc_ctrl_regs_pkg;
    localparam int BUS_W = 8;
    localparam int RES_W = 12;
    localparam int CH_W  = 3;

    // Control byte bit positions
    localparam int B_START = 7;
    localparam int B_BUSY  = 6;
    localparam int B_EN    = 5;
    localparam int B_FMT   = 4;

    typedef struct packed {
        logic             start;
        logic             busy;
        logic             en;
        logic             fmt;
        logic [CH_W-1:0]  chan;
        logic [BUS_W-1:0] res_hi;
        logic [BUS_W-1:0] res_lo;
        logic             req;
    } regs_t;
endpackage

// File: rtl/adc_start_seq.sv
module adc_start_seq (
    input  logic wr_ctrl,
    input  logic wr_start,
    input  logic start_q,
    output logic start_d,
    output logic trigger
);
    always_comb begin
        start_d = start_q;
        trigger = 1'b0;
        if (wr_ctrl) begin
            start_d = wr_start;
            // stored 1 implies an earlier 0->1 step; this write is the clear
            trigger = start_q && !wr_start;
        end
    end
endmodule

// File: rtl/adc_result_align.sv
module adc_result_align #(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             fmt,
    input  logic [RES_W-1:0] value,
    output logic [BUS_W-1:0] hi,
    output logic [BUS_W-1:0] lo
);
    localparam int LEFT_LO  = RES_W - BUS_W;
    localparam int RIGHT_HI = RES_W - BUS_W;

    always_comb begin
        hi = '0;
        lo = '0;
        if (fmt) begin
            hi[RIGHT_HI-1:0] = value[RES_W-1:BUS_W];
            lo               = value[BUS_W-1:0];
        end else begin
            hi               = value[RES_W-1:LEFT_LO];
            lo[LEFT_LO-1:0]  = value[LEFT_LO-1:0];
        end
    end
endmodule

// File: rtl/adc_reg_read.sv
module adc_reg_read #(
    parameter int ADDR_W = 2,
    parameter int BUS_W  = 8,
    parameter logic [ADDR_W-1:0] A_CTRL = 0,
    parameter logic [ADDR_W-1:0] A_HI   = 1,
    parameter logic [ADDR_W-1:0] A_LO   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  ctrl,
    input  logic [BUS_W-1:0]  hi,
    input  logic [BUS_W-1:0]  lo,
    output logic [BUS_W-1:0]  rdata
);
    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = ctrl;
            A_HI:    rdata = hi;
            A_LO:    rdata = lo;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_ctrl_regs_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              conv_en,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(2);

    regs_t st_q, st_d;

    logic             wr_ctrl;
    logic             start_d;
    logic             trigger;
    logic [BUS_W-1:0] al_hi, al_lo;
    logic [BUS_W-1:0] ctrl_rd;
    logic             unused_wbits;

    assign wr_ctrl      = bus_wr && (bus_addr == A_CTRL);
    assign unused_wbits = ^{bus_wdata[B_BUSY], bus_wdata[3]};

    adc_start_seq u_seq (
        .wr_ctrl  (wr_ctrl),
        .wr_start (bus_wdata[B_START]),
        .start_q  (st_q.start),
        .start_d  (start_d),
        .trigger  (trigger)
    );

    adc_result_align #(.RES_W(RES_W), .BUS_W(BUS_W)) u_align (
        .fmt   (st_q.fmt),
        .value (conv_data),
        .hi    (al_hi),
        .lo    (al_lo)
    );

    always_comb begin
        st_d       = st_q;
        st_d.req   = 1'b0;
        st_d.start = start_d;
        if (wr_ctrl) begin
            st_d.en   = bus_wdata[B_EN];
            st_d.fmt  = bus_wdata[B_FMT];
            st_d.chan = bus_wdata[CH_W-1:0];
        end
        if (!st_d.en) begin
            st_d.busy = 1'b0;                       // off: abandon
        end else if (st_q.busy) begin
            if (conv_done && st_q.en) begin
                st_d.busy   = 1'b0;
                st_d.res_hi = al_hi;
                st_d.res_lo = al_lo;
            end
        end else if (trigger) begin
            st_d.busy = 1'b1;
            st_d.req  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[B_START]  = st_q.start;
        ctrl_rd[B_BUSY]   = st_q.busy;
        ctrl_rd[B_EN]     = st_q.en;
        ctrl_rd[B_FMT]    = st_q.fmt;
        ctrl_rd[CH_W-1:0] = st_q.chan;
    end

    adc_reg_read #(.ADDR_W(ADDR_W), .BUS_W(BUS_W),
                   .A_CTRL(A_CTRL), .A_HI(A_HI), .A_LO(A_LO)) u_rd (
        .addr  (bus_addr),
        .ctrl  (ctrl_rd),
        .hi    (st_q.res_hi),
        .lo    (st_q.res_lo),
        .rdata (bus_rdata)
    );

    assign conv_en   = st_q.en;
    assign conv_req  = st_q.req;
    assign conv_chan = st_q.chan;

    AST_REQ_NEEDS_EN:   assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> conv_en);                                        // R7
    AST_REQ_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);                                      // R4
    AST_REQ_WITH_BUSY:  assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> st_q.busy);                                      // R5
    AST_BUSY_NEEDS_EN:  assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> conv_en);                                       // R10
    AST_FROZEN_OFF:     assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> ($stable(st_q.res_hi) && $stable(st_q.res_lo))); // R10
    AST_DONE_CLEARS:    assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && conv_done) |=> !st_q.busy);                     // R5
    AST_BUSY_NO_REQ:    assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !conv_done) |=> !conv_req);                     // R6
endmodule

// File: tb/adc_ctrl_regs_tb.sv
module adc_ctrl_regs_tb_top;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        conv_en, conv_req;
    logic [2:0]  conv_chan;
    logic        model_done = 1'b0, inj_done = 1'b0;
    logic [11:0] model_data = '0, inj_data = '0, next_data = '0;
    logic [11:0] conv_data;
    int          cnt = 0;
    int          req_cnt = 0;
    logic [2:0]  last_chan = '0;
    int          errors = 0, checks = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    assign conv_data = inj_done ? inj_data : model_data;

    adc_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_en(conv_en),
        .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_done(model_done | inj_done), .conv_data(conv_data)
    );

    // fixed-latency converter core model
    always @(posedge clk) begin
        model_done <= 1'b0;
        if (conv_req) begin
            req_cnt   <= req_cnt + 1;
            last_chan <= conv_chan;
        end
        if (!conv_en) cnt <= 0;
        else if (conv_req) begin
            cnt <= LAT;
            model_data <= next_data;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) model_done <= 1'b1;
        end
    end

    function automatic logic [15:0] fmt_exp(input logic f, input logic [11:0] d);
        return f ? {4'b0, d[11:8], d[7:0]} : {d[11:4], 4'b0, d[3:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int i = 0; i < 30; i++) begin
            rd(2'd0, c);
            if (!c[6]) break;
            @(negedge clk);
        end
    endtask

    task automatic check_res(input string req, input logic [15:0] e);
        logic [7:0] h, l;
        rd(2'd1, h); rd(2'd2, l);
        check(req, {h, l}, e);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int base;
        logic [15:0] held;
        void'($urandom(32'h1d5e));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 hi", v, 8'h00);
        rd(2'd2, v); check("R1 lo", v, 8'h00);
        rd(2'd3, v); check("R1 addr3", v, 8'h00);
        // R2: bit3 and busy write
        wr(2'd0, 8'h4F); rd(2'd0, v); check("R2 bit3/busy", v, 8'h07);
        // R11
        check("R11 en off", conv_en, 1'b0);
        wr(2'd0, 8'h20); check("R11 en on", conv_en, 1'b1);
        // R3: clear without prior set
        base = req_cnt;
        wr(2'd0, 8'h20); check("R3 no set", conv_req, 1'b0);
        wr(2'd0, 8'hA0); wr(2'd0, 8'hA0); check("R3 set only", conv_req, 1'b0);
        check("R3 count", req_cnt - base, 0);
        // R4/R5/R8: valid sequence, fmt0, input 6
        next_data = 12'hABC;
        wr(2'd0, 8'h26);
        check("R4 req pulse", conv_req, 1'b1);
        check("R4 chan", conv_chan, 3'b110);
        rd(2'd0, v); check("R5 busy set", v[6], 1'b1);
        @(negedge clk); check("R4 one cycle", conv_req, 1'b0);
        // R6: restart while busy
        wr(2'd0, 8'hA6); wr(2'd0, 8'h26); check("R6 no req", conv_req, 1'b0);
        wait_idle();
        check("R6 count", req_cnt - base, 1);
        rd(2'd0, v); check("R5 busy clr", v[6], 1'b0);
        check_res("R8 fmt0", fmt_exp(1'b0, 12'hABC));
        // R5: stray done while idle
        inj_data = 12'h123; inj_done = 1'b1; @(negedge clk); inj_done = 1'b0;
        check_res("R5 stray done", fmt_exp(1'b0, 12'hABC));
        // R7: sequence while disabled
        base = req_cnt;
        wr(2'd0, 8'h80); wr(2'd0, 8'h00);
        rd(2'd0, v); check("R7 busy", v[6], 1'b0);
        check("R7 count", req_cnt - base, 0);
        // R10: abandon
        held = fmt_exp(1'b0, 12'hABC);
        next_data = 12'h5A5;
        wr(2'd0, 8'hB7); wr(2'd0, 8'h37);
        @(negedge clk);
        wr(2'd0, 8'h17);
        rd(2'd0, v); check("R10 busy drop", v[6], 1'b0);
        repeat (LAT + 3) @(negedge clk);
        check_res("R10 frozen", held);
        inj_data = 12'hFFF; inj_done = 1'b1; @(negedge clk); inj_done = 1'b0;
        check_res("R10 frozen off", held);
        // random: R8/R9/R4
        for (int i = 0; i < 40; i++) begin
            logic [2:0] ch;
            logic f;
            ch = 3'($urandom);
            f = 1'($urandom);
            next_data = 12'($urandom);
            wr(2'd0, {3'b101, f, 1'b0, ch});
            wr(2'd0, {3'b001, f, 1'b0, ch});
            check("R4 rand req", conv_req, 1'b1);
            check("R4 rand chan", conv_chan, ch);
            wait_idle();
            check_res(f ? "R9 rand" : "R8 rand", fmt_exp(f, next_data));
        end
        check("R4 last chan", last_chan, conv_chan);
        finish_run();
    end
endmodule